// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block keeps track of the open-row state of a small set of DRAM banks and turns each accepted read or write request into a correctly spaced series of memory commands. A request names a bank, a row and a column, and it says whether the access is a write and whether the row should close once the access is done. The sequencer compares the request with the bank's state. If the row is already open it issues the column command at once. If the bank is closed it activates the row first. If another row is open it precharges the bank, activates the new row, and only then issues the column command.

Commands leave on a single registered command port that carries at most one command per cycle. The port holds a 2-bit code together with the bank, row, column, write and auto-close fields. A separate pulse marks the cycle in which the data burst begins, a fixed CAS latency after the column command, and a level output covers the cycles in which the burst holds the data bus. The host sees a ready signal. Ready is high only when the addressed bank can take a new request and the data bus spacing allows another column command.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset every bank is closed, `cmd_code` is NOP (0), `req_ready` is high, and `burst_start` and `data_active` are low. The first access to any bank therefore begins with an activate.
- R2: When the requested row is already open in its bank, the column command (code 3) appears on the cycle after acceptance, with no precharge or activate before it.
- R3: When the target bank is closed, an activate (code 2) appears on the cycle after acceptance, NOPs follow, and the column command appears exactly T_RCD cycles after the activate.
- R4: When a different row is open in the target bank, a precharge (code 1) appears on the cycle after acceptance, an activate follows exactly T_RP cycles later, and the column command follows T_RCD cycles after the activate, with NOPs in every cycle between them.
- R5: The command port carries the request's bank on every command, its row on the activate, and its column, write flag and auto-close flag on the column command.
- R6: `burst_start` pulses for one cycle exactly T_CL cycles after the column command appears. `data_active` is high for exactly BURST_CYC consecutive cycles starting with that pulse.
- R7: A column command with the auto-close flag set closes its bank, so the next access to that bank takes the closed path of R3. `req_ready` for that bank stays low until T_RP cycles after the column command, while other banks become ready once the bus spacing of R8 has elapsed.
- R8: `req_ready` is low while a precharge or activate sequence is in progress, and for BURST_CYC-1 cycles after every column command, so that column commands are at least BURST_CYC cycles apart.
- R9: A bank holds at most one open row. An activate is never issued to a bank that already has a row open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row after the access |
| cmd_code | output | 2 | 0 NOP, 1 precharge, 2 activate, 3 read/write |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row of the command |
| cmd_col | output | COL_W | Column of the command |
| cmd_write | output | 1 | Column command is a write |
| cmd_autopre | output | 1 | Column command closes the row afterwards |
| burst_start | output | 1 | First cycle of a data burst |
| data_active | output | 1 | Data bus occupied by a burst |

## Verification
A corrupted open-row table shows up on the very next request to the affected bank. The sequencer then issues the wrong first command, for example a column command where a precharge belongs, or an activate to a bank that is already open, and that command is visible on the cycle after acceptance. A wrong wait counter moves the activate or the column command by one or more cycles. A wrong latency pipeline moves `burst_start` away from its fixed offset. Every such fault therefore appears on the command or burst outputs within the T_RP + T_RCD + T_CL + BURST_CYC cycles of a single request.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_ACT = 2'd2,
    CMD_RW  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_RP  = 2'd1,
    ST_WAIT_RCD = 2'd2
  } seq_state_e;

endpackage

// File: rtl/dram_bank_table.sv
module dram_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int T_RP      = 5,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int TMR_W    = $clog2(T_RP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] look_bank,
  output logic              look_open,
  output logic [ROW_W-1:0]  look_row,
  output logic              look_busy,
  input  logic              open_en,
  input  logic [BANK_W-1:0] open_bank,
  input  logic [ROW_W-1:0]  open_row,
  input  logic              close_en,
  input  logic              close_arm,
  input  logic [BANK_W-1:0] close_bank
);

  logic [NUM_BANKS-1:0] open_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];
  logic [TMR_W-1:0]     tmr_q [NUM_BANKS];

  // Row storage: plain write-enabled array, no reset, RAM friendly.
  always_ff @(posedge clk) begin
    if (open_en) row_q[open_bank] <= open_row;
  end

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        open_q[gb] <= 1'b0;
        tmr_q[gb]  <= '0;
      end else begin
        if (tmr_q[gb] != '0) tmr_q[gb] <= tmr_q[gb] - 1'b1;
        if (close_en && close_bank == BANK_W'(gb)) open_q[gb] <= 1'b0;
        if (close_arm && close_bank == BANK_W'(gb)) tmr_q[gb] <= TMR_W'(T_RP - 1);
        if (open_en && open_bank == BANK_W'(gb)) open_q[gb] <= 1'b1;
      end
    end
  end

  assign look_open = open_q[look_bank];
  assign look_row  = row_q[look_bank];
  assign look_busy = (tmr_q[look_bank] != '0);

  // R9: activate only lands on a closed bank
  a_r9_act_to_closed_bank: assert property (@(posedge clk) disable iff (rst)
    open_en |-> !open_q[open_bank]);

  // R7: no activate while the bank is still recovering from auto-close
  a_r7_act_after_recovery: assert property (@(posedge clk) disable iff (rst)
    open_en |-> (tmr_q[open_bank] == '0));

endmodule

// File: rtl/dram_burst_timer.sv
module dram_burst_timer #(
  parameter int T_CL      = 4,
  parameter int BURST_CYC = 4,
  localparam int SR_LEN   = T_CL + BURST_CYC - 1
) (
  input  logic clk,
  input  logic rst,
  input  logic rw_seen,
  output logic burst_start,
  output logic data_active
);

  logic [SR_LEN-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[SR_LEN-2:0], rw_seen};
  end

  assign burst_start = pipe_q[T_CL-1];
  assign data_active = |pipe_q[T_CL-1 +: BURST_CYC];

  // R6: column spacing keeps burst starts apart
  a_r6_burst_spacing: assert property (@(posedge clk) disable iff (rst)
    (BURST_CYC > 1 && burst_start) |=> !burst_start);

endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int T_RP      = 5,
  parameter int T_RCD     = 3,
  parameter int T_CL      = 4,
  parameter int BURST_CYC = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int T_MAX    = (T_RP > T_RCD) ? T_RP : T_RCD,
  localparam int CNT_W    = $clog2(T_MAX + 1),
  localparam int GAP_W    = $clog2(BURST_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  input  logic              req_autopre,
  output logic [1:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_write,
  output logic              cmd_autopre,
  output logic              burst_start,
  output logic              data_active
);

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GAP_W-1:0] gap_q;

  cmd_e              cmd_q, cmd_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic              we_q, we_d, ap_q, ap_d;

  // Request held while its precharge / activate sequence runs
  logic [BANK_W-1:0] p_bank;
  logic [ROW_W-1:0]  p_row;
  logic [COL_W-1:0]  p_col;
  logic              p_we, p_ap;

  logic              look_open, look_busy;
  logic [ROW_W-1:0]  look_row;
  logic              accept, row_hit;

  dram_bank_table #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .T_RP      (T_RP)
  ) u_table (
    .clk        (clk),
    .rst        (rst),
    .look_bank  (req_bank),
    .look_open  (look_open),
    .look_row   (look_row),
    .look_busy  (look_busy),
    .open_en    (cmd_d == CMD_ACT),
    .open_bank  (bank_d),
    .open_row   (row_d),
    .close_en   ((cmd_d == CMD_PRE) || (cmd_d == CMD_RW && ap_d)),
    .close_arm  (cmd_d == CMD_RW && ap_d),
    .close_bank (bank_d)
  );

  assign req_ready = (state_q == ST_IDLE) && (gap_q == '0) && !look_busy;
  assign accept    = req_valid && req_ready;
  assign row_hit   = look_open && (look_row == req_row);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cmd_d   = CMD_NOP;
    bank_d  = bank_q;
    row_d   = row_q;
    col_d   = col_q;
    we_d    = we_q;
    ap_d    = ap_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          bank_d = req_bank;
          row_d  = req_row;
          col_d  = req_col;
          we_d   = req_write;
          ap_d   = req_autopre;
          if (row_hit) begin
            cmd_d = CMD_RW;
          end else if (look_open) begin
            cmd_d   = CMD_PRE;
            state_d = ST_WAIT_RP;
            cnt_d   = CNT_W'(T_RP - 1);
          end else begin
            cmd_d   = CMD_ACT;
            state_d = ST_WAIT_RCD;
            cnt_d   = CNT_W'(T_RCD - 1);
          end
        end
      end
      ST_WAIT_RP: begin
        if (cnt_q == '0) begin
          cmd_d   = CMD_ACT;
          bank_d  = p_bank;
          row_d   = p_row;
          state_d = ST_WAIT_RCD;
          cnt_d   = CNT_W'(T_RCD - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WAIT_RCD: begin
        if (cnt_q == '0) begin
          cmd_d   = CMD_RW;
          bank_d  = p_bank;
          row_d   = p_row;
          col_d   = p_col;
          we_d    = p_we;
          ap_d    = p_ap;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      gap_q   <= '0;
      cmd_q   <= CMD_NOP;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      we_q    <= 1'b0;
      ap_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cmd_q   <= cmd_d;
      bank_q  <= bank_d;
      row_q   <= row_d;
      col_q   <= col_d;
      we_q    <= we_d;
      ap_q    <= ap_d;
      if (cmd_d == CMD_RW)      gap_q <= GAP_W'(BURST_CYC - 1);
      else if (gap_q != '0)     gap_q <= gap_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      p_bank <= req_bank;
      p_row  <= req_row;
      p_col  <= req_col;
      p_we   <= req_write;
      p_ap   <= req_autopre;
    end
  end

  dram_burst_timer #(
    .T_CL      (T_CL),
    .BURST_CYC (BURST_CYC)
  ) u_burst (
    .clk         (clk),
    .rst         (rst),
    .rw_seen     (cmd_q == CMD_RW),
    .burst_start (burst_start),
    .data_active (data_active)
  );

  assign cmd_code    = cmd_q;
  assign cmd_bank    = bank_q;
  assign cmd_row     = row_q;
  assign cmd_col     = col_q;
  assign cmd_write   = we_q;
  assign cmd_autopre = ap_q;

  // R1: the first cycle after reset carries no command
  a_r1_reset_nop: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmd_code == 2'd0));

  // R4: a precharge is followed by idle cycles on the command port
  a_r4_pre_then_nop: assert property (@(posedge clk) disable iff (rst)
    (T_RP > 1 && cmd_code == 2'd1) |=> (cmd_code == 2'd0));

  // R8: no request is taken in the cycle right after a column command
  a_r8_rw_blocks_ready: assert property (@(posedge clk) disable iff (rst)
    (BURST_CYC > 1 && cmd_code == 2'd3) |-> !req_ready);

  // R8: no request is taken while a precharge/activate sequence waits
  a_r8_act_blocks_ready: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == 2'd2 || cmd_code == 2'd1) |-> !req_ready);

endmodule

// File: tb/tb_dram_bank_seq.sv
module tb_dram_bank_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NB     = 4;
  localparam int RW_    = 12;
  localparam int CW     = 8;
  localparam int TRP    = 5;
  localparam int TRCD   = 3;
  localparam int TCL    = 4;
  localparam int BURST  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_bank = '0;
  logic [RW_-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic req_write = 1'b0, req_autopre = 1'b0;
  logic [1:0] cmd_code;
  logic [1:0] cmd_bank;
  logic [RW_-1:0] cmd_row;
  logic [CW-1:0] cmd_col;
  logic cmd_write, cmd_autopre, burst_start, data_active;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_bank_seq #(
    .NUM_BANKS(NB), .ROW_W(RW_), .COL_W(CW),
    .T_RP(TRP), .T_RCD(TRCD), .T_CL(TCL), .BURST_CYC(BURST)
  ) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_write(req_write), .req_autopre(req_autopre),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_write(cmd_write), .cmd_autopre(cmd_autopre),
    .burst_start(burst_start), .data_active(data_active)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit open_m [NB];
  int row_m [NB];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // 0 = hit, 1 = closed, 2 = conflict
  function automatic int kind_of(input int b, input int r);
    if (open_m[b] && row_m[b] == r) return 0;
    if (!open_m[b]) return 1;
    return 2;
  endfunction

  task automatic expect_cmd(input int code, input string tag);
    chk(cmd_code == 2'(code), tag, cmd_code, code);
  endtask

  task automatic do_req(input int b, input int r, input int c, input bit we, input bit ap);
    int kind;
    int other;
    kind = kind_of(b, r);
    req_bank = 2'(b); req_row = RW_'(r); req_col = CW'(c);
    req_write = we; req_autopre = ap; req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (kind == 0) begin
      expect_cmd(3, "R2 hit column command");
    end else if (kind == 1) begin
      expect_cmd(2, "R3 closed bank activate");
      chk(cmd_row == RW_'(r), "R5 activate row", cmd_row, r);
      chk(cmd_bank == 2'(b), "R5 activate bank", cmd_bank, b);
      chk(req_ready == 1'b0, "R8 ready low in sequence", req_ready, 0);
      for (int k = 1; k < TRCD; k++) begin
        @(negedge clk); expect_cmd(0, "R3 nop before column");
      end
      @(negedge clk); expect_cmd(3, "R3 column after T_RCD");
    end else begin
      expect_cmd(1, "R4 conflict precharge");
      chk(cmd_bank == 2'(b), "R5 precharge bank", cmd_bank, b);
      for (int k = 1; k < TRP; k++) begin
        @(negedge clk); expect_cmd(0, "R4 nop during T_RP");
      end
      @(negedge clk); expect_cmd(2, "R4 activate after T_RP");
      chk(cmd_row == RW_'(r), "R5 activate row", cmd_row, r);
      for (int k = 1; k < TRCD; k++) begin
        @(negedge clk); expect_cmd(0, "R4 nop during T_RCD");
      end
      @(negedge clk); expect_cmd(3, "R4 column after T_RCD");
    end
    chk(cmd_bank == 2'(b), "R5 column bank", cmd_bank, b);
    chk(cmd_col == CW'(c), "R5 column col", cmd_col, c);
    chk(cmd_write == we, "R5 column write flag", cmd_write, we);
    chk(cmd_autopre == ap, "R5 column auto-close flag", cmd_autopre, ap);
    chk(req_ready == 1'b0, "R8 ready low after column", req_ready, 0);
    open_m[b] = !ap;
    row_m[b] = r;
    other = (b + 1) % NB;
    for (int j = 1; j <= TCL + BURST; j++) begin
      @(negedge clk);
      if (j < TCL) chk(burst_start == 1'b0, "R6 no early burst", burst_start, 0);
      if (j == TCL) chk(burst_start == 1'b1, "R6 burst start at T_CL", burst_start, 1);
      if (j > TCL) chk(burst_start == 1'b0, "R6 single pulse", burst_start, 0);
      if (j >= TCL && j < TCL + BURST)
        chk(data_active == 1'b1, "R6 bus busy in burst", data_active, 1);
      if (j == TCL + BURST)
        chk(data_active == 1'b0, "R6 bus free after burst", data_active, 0);
      if (j < BURST - 1)
        chk(req_ready == 1'b0, "R8 column spacing", req_ready, 0);
      if (ap && TRP > BURST && j == BURST - 1) begin
        req_bank = 2'(other); #1;
        chk(req_ready == 1'b1, "R7 other bank ready", req_ready, 1);
        req_bank = 2'(b); #1;
        chk(req_ready == 1'b0, "R7 closed bank recovering", req_ready, 0);
      end
      if (ap && j == TRP - 1) begin
        req_bank = 2'(b); #1;
        chk(req_ready == 1'b1, "R7 bank ready after T_RP", req_ready, 1);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin open_m[i] = 1'b0; row_m[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_code == 2'd0, "R1 reset nop", cmd_code, 0);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(burst_start == 1'b0, "R1 reset burst", burst_start, 0);
    chk(data_active == 1'b0, "R1 reset bus", data_active, 0);

    // Directed corners
    do_req(0, 5, 17, 1'b0, 1'b0);   // R1/R3 first touch is closed
    do_req(0, 5, 18, 1'b1, 1'b0);   // R2 hit
    do_req(0, 9, 3, 1'b0, 1'b0);    // R4 conflict
    do_req(1, 7, 200, 1'b1, 1'b1);  // R3 + R7 auto-close
    do_req(1, 7, 201, 1'b0, 1'b0);  // R7 same row is closed again
    do_req(3, 4095, 255, 1'b1, 1'b1);
    do_req(2, 0, 0, 1'b0, 1'b0);

    // Constrained random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 60; n++) begin
      int b, r, c;
      bit we, ap;
      b  = int'($urandom_range(NB - 1, 0));
      r  = int'($urandom_range(3, 0));
      c  = int'($urandom_range(255, 0));
      we = 1'($urandom_range(1, 0));
      ap = ($urandom_range(4, 0) == 0);
      do_req(b, r, c, we, ap);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule